// File: doc/BRIEF.md
# Register-Mapped Interrupt Match Controller

This block gathers interrupt events from up to 32 interrupt-capable registers of a memory-mapped register file and reduces them to one interrupt request line. Each source drives a one-cycle event pulse in the cycle its register latches a new value. The block keeps two software-visible registers. The match register records which sources have fired, with bit i belonging to the i-th interrupt-capable source in table order, whatever that source's address is. The enable register masks which recorded sources may raise the request.

Software works through a plain register access port with an address, a write enable with write data, and a read enable with read data. The port takes one access per cycle and never stalls, so there is no back-pressure. A read of the match register returns the recorded bits and clears them. An event that arrives in the same cycle as that read is kept for the next read.

A parameter picks the request style. In level style the request stays high while any enabled match bit is set. In strobe style the block gives one single-cycle pulse and then issues no further pulse until software has read the match register. This keeps a burst of events from producing a burst of interrupts.

Top module: `irq_match_ctrl`

## Requirements
- R1: A synchronous active-high reset sets the match register to zero, the enable register to all ones, the request low, the read data to zero, and arms the strobe generator. The reset takes priority over an event in the same cycle.
- R2: An event on source i sets match bit i at the next clock edge. Bits already set stay set, because events are ORed in.
- R3: A read at MATCH_ADDR (default 0x04) returns the match value held in the read cycle on reg_rdata one cycle later, and clears the match register at that edge.
- R4: An event that arrives in the same cycle as a clearing read of the match register is held in the match register after the read.
- R5: The enable register at ENABLE_ADDR (default 0x00) is read-write. A write stores reg_wdata, and a read returns the stored value one cycle later.
- R6: A source whose enable bit is zero still sets its match bit but does not raise the request.
- R7: In level style (IRQ_PULSE=0) the request is high exactly while some bit is set in both match and enable. It rises in the cycle after the event edge and falls in the cycle after the clearing read.
- R8: In strobe style (IRQ_PULSE=1, the default) the request is a one-cycle pulse in the first cycle in which an enabled match bit is pending while the generator is armed. After that pulse no further pulse is issued until the match register has been read.
- R9: A write to MATCH_ADDR has no effect. A write to an unmapped address has no effect. A read of an unmapped address returns zero.
- R10: reg_rdata changes only in the cycle after a read and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_event | input | NUM_SRC | One-cycle latch event per interrupt-capable source, in table order |
| reg_addr | input | ADDR_W | Register access byte address |
| reg_wr | input | 1 | Write enable |
| reg_wdata | input | DATA_W | Write data |
| reg_rd | input | 1 | Read enable |
| reg_rdata | output | DATA_W | Read data, valid the cycle after reg_rd |
| irq | output | 1 | Interrupt request, strobe or level per IRQ_PULSE |

## Verification
An event or an enable write is taken at one edge, and its effect is due at the next sample: the match bit, and the request in either style, show up in the cycle after the event edge. Read data comes through one register, so it appears one cycle after reg_rd. A clearing read lowers the level request and re-arms the strobe in the cycle after it. The bench applies each vector in one cycle and samples two nanoseconds after the following rising edge, so every result is checked in the first cycle it is due. It runs a strobe-style and a level-style instance side by side on the same stimulus.

// File: rtl/irq_match_pkg.sv
package irq_match_pkg;
  typedef struct packed {
    logic en_wr;
    logic en_rd;
    logic match_rd;
    logic any_rd;
  } irq_hit_t;
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_match_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] ENABLE_ADDR = 'h00,
  parameter logic [ADDR_W-1:0] MATCH_ADDR  = 'h04
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output irq_hit_t          hit
);
  logic at_en, at_match;

  always_comb begin
    at_en        = (addr == ENABLE_ADDR);
    at_match     = (addr == MATCH_ADDR);
    hit.en_wr    = wr & at_en;
    hit.en_rd    = rd & at_en;
    hit.match_rd = rd & at_match;
    hit.any_rd   = rd;
  end
endmodule

// File: rtl/irq_match_latch.sv
module irq_match_latch #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] event_in,
  input  logic               clear,
  output logic [NUM_SRC-1:0] match_q
);
  logic [NUM_SRC-1:0] held;

  // A clearing read drops the old bits, but events from the same cycle survive.
  always_comb held = clear ? '0 : match_q;

  always_ff @(posedge clk) begin
    if (rst) match_q <= '0;
    else     match_q <= held | event_in;
  end
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr,
  input  logic [NUM_SRC-1:0] wdata,
  output logic [NUM_SRC-1:0] enable_q
);
  always_ff @(posedge clk) begin
    if (rst)     enable_q <= '1;
    else if (wr) enable_q <= wdata;
  end
endmodule

// File: rtl/irq_request_gen.sv
module irq_request_gen #(
  parameter int NUM_SRC   = 32,
  parameter bit IRQ_PULSE = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] match_q,
  input  logic [NUM_SRC-1:0] enable_q,
  input  logic               rearm,
  output logic               irq
);
  logic pending;

  always_comb pending = |(match_q & enable_q);

  generate
    if (IRQ_PULSE) begin : g_strobe
      logic armed;
      always_comb irq = armed & pending;
      always_ff @(posedge clk) begin
        if (rst)        armed <= 1'b1;
        else if (rearm) armed <= 1'b1;
        else if (irq)   armed <= 1'b0;
      end
    end else begin : g_level
      always_comb irq = pending;
    end
  endgenerate
endmodule

// File: rtl/irq_match_ctrl.sv
module irq_match_ctrl
  import irq_match_pkg::*;
#(
  parameter int NUM_SRC   = 32,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter logic [ADDR_W-1:0] ENABLE_ADDR = 'h00,
  parameter logic [ADDR_W-1:0] MATCH_ADDR  = 'h04,
  parameter bit IRQ_PULSE = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_event,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic [DATA_W-1:0]  reg_wdata,
  input  logic               reg_rd,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               irq
);
  localparam int SRC_LIMIT = 32;

  generate
    if (NUM_SRC > SRC_LIMIT || NUM_SRC > DATA_W || NUM_SRC < 1) begin : g_bad_cfg
      $error("irq_match_ctrl: NUM_SRC out of range");
    end
  endgenerate

  irq_hit_t           hit;
  logic [NUM_SRC-1:0] match_q;
  logic [NUM_SRC-1:0] enable_q;
  logic [DATA_W-1:0]  rd_mux;

  irq_reg_decode #(
    .ADDR_W(ADDR_W), .ENABLE_ADDR(ENABLE_ADDR), .MATCH_ADDR(MATCH_ADDR)
  ) u_decode (
    .addr(reg_addr), .wr(reg_wr), .rd(reg_rd), .hit(hit)
  );

  irq_match_latch #(.NUM_SRC(NUM_SRC)) u_match (
    .clk(clk), .rst(rst), .event_in(src_event),
    .clear(hit.match_rd), .match_q(match_q)
  );

  irq_enable_reg #(.NUM_SRC(NUM_SRC)) u_enable (
    .clk(clk), .rst(rst), .wr(hit.en_wr),
    .wdata(reg_wdata[NUM_SRC-1:0]), .enable_q(enable_q)
  );

  irq_request_gen #(.NUM_SRC(NUM_SRC), .IRQ_PULSE(IRQ_PULSE)) u_req (
    .clk(clk), .rst(rst), .match_q(match_q), .enable_q(enable_q),
    .rearm(hit.match_rd), .irq(irq)
  );

  always_comb begin
    rd_mux = '0;
    if (hit.en_rd)         rd_mux[NUM_SRC-1:0] = enable_q;
    else if (hit.match_rd) rd_mux[NUM_SRC-1:0] = match_q;
  end

  always_ff @(posedge clk) begin
    if (rst)             reg_rdata <= '0;
    else if (hit.any_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/irq_match_ctrl_chk.sv
module irq_match_ctrl_chk #(
  parameter int NUM_SRC   = 32,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter logic [ADDR_W-1:0] ENABLE_ADDR = 'h00,
  parameter logic [ADDR_W-1:0] MATCH_ADDR  = 'h04,
  parameter bit IRQ_PULSE = 1'b1
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] src_event,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic               reg_wr,
  input logic [DATA_W-1:0]  reg_wdata,
  input logic               reg_rd,
  input logic [DATA_W-1:0]  reg_rdata,
  input logic               irq,
  input logic [NUM_SRC-1:0] match_q,
  input logic [NUM_SRC-1:0] enable_q
);
  logic rd_match, wr_en, wr_match, strobe_seen;
  always_comb begin
    rd_match = reg_rd && reg_addr == MATCH_ADDR;
    wr_en    = reg_wr && reg_addr == ENABLE_ADDR;
    wr_match = reg_wr && reg_addr == MATCH_ADDR;
  end

  always_ff @(posedge clk) begin
    if (rst)           strobe_seen <= 1'b0;
    else if (rd_match) strobe_seen <= 1'b0;
    else if (irq)      strobe_seen <= 1'b1;
  end

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (match_q == '0 && enable_q == '1 && reg_rdata == '0));

  a_r2_event_sets: assert property (@(posedge clk) disable iff (rst)
    (|src_event) |=> ((match_q & $past(src_event)) == $past(src_event)));

  a_r3_read_value: assert property (@(posedge clk) disable iff (rst)
    rd_match |=> (reg_rdata[NUM_SRC-1:0] == $past(match_q)));

  a_r4_clear_keeps_event: assert property (@(posedge clk) disable iff (rst)
    rd_match |=> (match_q == $past(src_event)));

  a_r5_enable_write: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (enable_q == $past(reg_wdata[NUM_SRC-1:0])));

  a_r6_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    ((match_q & enable_q) == '0) |-> !irq);

  a_r8_one_strobe: assert property (@(posedge clk) disable iff (rst)
    (IRQ_PULSE && strobe_seen) |-> !irq);

  a_r9_match_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_match && !reg_rd && src_event == '0) |=> $stable(match_q));

  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata));
endmodule

bind irq_match_ctrl irq_match_ctrl_chk #(
  .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .ENABLE_ADDR(ENABLE_ADDR), .MATCH_ADDR(MATCH_ADDR), .IRQ_PULSE(IRQ_PULSE)
) u_chk (
  .clk(clk), .rst(rst), .src_event(src_event), .reg_addr(reg_addr),
  .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
  .reg_rdata(reg_rdata), .irq(irq), .match_q(match_q), .enable_q(enable_q)
);

// File: tb/irq_match_ctrl_bench.sv
module irq_match_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] src_event;
  logic [7:0]  reg_addr;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic        reg_rd;
  logic [31:0] rdata_p, rdata_l;
  logic        irq_p, irq_l;
  int          n_checks = 0;
  int          n_errors = 0;

  always #10 clk = ~clk;

  irq_match_ctrl u_irq_match_ctrl (
    .clk(clk), .rst(rst), .src_event(src_event), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
    .reg_rdata(rdata_p), .irq(irq_p)
  );

  irq_match_ctrl #(.IRQ_PULSE(1'b0)) u_irq_match_ctrl_lvl (
    .clk(clk), .rst(rst), .src_event(src_event), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
    .reg_rdata(rdata_l), .irq(irq_l)
  );

  // fields: event, addr, wr, wdata, rd, expected rdata, expected strobe irq, expected level irq
  localparam int NV = 19;
  localparam logic [107:0] VEC [NV] = '{
    {32'h0,   8'h00, 1'b0, 32'h0,        1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0}, // R1 R5 enable reset value
    {32'h0,   8'h00, 1'b1, 32'h0000_00FF, 1'b0, 32'hFFFF_FFFF, 1'b0, 1'b0}, // R5 R10 write, rdata holds
    {32'h0,   8'h00, 1'b0, 32'h0,        1'b1, 32'h0000_00FF, 1'b0, 1'b0}, // R5 read back
    {32'h100, 8'h00, 1'b0, 32'h0,        1'b0, 32'h0000_00FF, 1'b0, 1'b0}, // R6 masked source
    {32'h0,   8'h04, 1'b0, 32'h0,        1'b1, 32'h0000_0100, 1'b0, 1'b0}, // R6 R3 bit set anyway
    {32'h5,   8'h00, 1'b0, 32'h0,        1'b0, 32'h0000_0100, 1'b1, 1'b1}, // R2 R7 R8 rise
    {32'h2,   8'h00, 1'b0, 32'h0,        1'b0, 32'h0000_0100, 1'b0, 1'b1}, // R8 one cycle
    {32'h0,   8'h00, 1'b0, 32'h0,        1'b0, 32'h0000_0100, 1'b0, 1'b1}, // R7 level holds
    {32'h0,   8'h04, 1'b1, 32'h0,        1'b0, 32'h0000_0100, 1'b0, 1'b1}, // R9 match write ignored
    {32'h8,   8'h04, 1'b0, 32'h0,        1'b1, 32'h0000_0007, 1'b1, 1'b1}, // R2 R3 R4 read with event
    {32'h0,   8'h04, 1'b0, 32'h0,        1'b1, 32'h0000_0008, 1'b0, 1'b0}, // R4 R7 kept event, then drop
    {32'h0,   8'h08, 1'b0, 32'h0,        1'b1, 32'h0000_0000, 1'b0, 1'b0}, // R9 unmapped read
    {32'h0,   8'h08, 1'b1, 32'hFFFF_FFFF, 1'b0, 32'h0000_0000, 1'b0, 1'b0}, // R9 unmapped write
    {32'h0,   8'h00, 1'b0, 32'h0,        1'b1, 32'h0000_00FF, 1'b0, 1'b0}, // R9 enable untouched
    {32'h1,   8'h00, 1'b0, 32'h0,        1'b0, 32'h0000_00FF, 1'b1, 1'b1}, // R8 rearmed strobe
    {32'h0,   8'h00, 1'b0, 32'h0,        1'b0, 32'h0000_00FF, 1'b0, 1'b1}, // R8 R7
    {32'h1,   8'h00, 1'b0, 32'h0,        1'b0, 32'h0000_00FF, 1'b0, 1'b1}, // R8 no strobe before read
    {32'h0,   8'h00, 1'b1, 32'h0,        1'b0, 32'h0000_00FF, 1'b0, 1'b0}, // R6 R7 disable all
    {32'h0,   8'h04, 1'b0, 32'h0,        1'b1, 32'h0000_0001, 1'b0, 1'b0}  // R6 R3 bit still recorded
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] ev, input logic [7:0] a, input logic w,
                      input logic [31:0] wd, input logic r);
    src_event = ev; reg_addr = a; reg_wr = w; reg_wdata = wd; reg_rd = r;
    @(posedge clk);
    #2;
    src_event = '0; reg_wr = 1'b0; reg_rd = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_errors++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    rst = 1'b1; src_event = '0; reg_addr = '0; reg_wr = 0; reg_wdata = '0; reg_rd = 0;
    repeat (3) @(posedge clk);
    #2;
    rst = 1'b0;
    // R1 reset outputs
    check(irq_p == 1'b0 && irq_l == 1'b0, "R1 irq low after reset", {30'b0, irq_p, irq_l}, 32'h0);
    check(rdata_p == 32'h0 && rdata_l == 32'h0, "R1 rdata zero", rdata_p, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [107:0] v;
      v = VEC[i];
      step(v[107:76], v[75:68], v[67], v[66:35], v[34]);
      check(rdata_p == v[33:2], $sformatf("vec%0d rdata strobe inst", i), rdata_p, v[33:2]);
      check(rdata_l == v[33:2], $sformatf("vec%0d rdata level inst", i), rdata_l, v[33:2]);
      check(irq_p == v[1], $sformatf("vec%0d R8 strobe irq", i), {31'b0, irq_p}, {31'b0, v[1]});
      check(irq_l == v[0], $sformatf("vec%0d R7 level irq", i), {31'b0, irq_l}, {31'b0, v[0]});
    end

    // R2 every source bit, enable restored
    step(32'h0, 8'h00, 1'b1, 32'hFFFF_FFFF, 1'b0);
    step(32'hFFFF_FFFF, 8'h00, 1'b0, 32'h0, 1'b0);
    check(irq_p == 1'b1, "R8 strobe after rearm", {31'b0, irq_p}, 32'h1);
    step(32'h0, 8'h04, 1'b0, 32'h0, 1'b1);
    check(rdata_p == 32'hFFFF_FFFF, "R2 all bits recorded", rdata_p, 32'hFFFF_FFFF);

    // R1 reset during activity wins over a same-cycle event
    step(32'h0000_0030, 8'h00, 1'b1, 32'h0000_000F, 1'b0);
    rst = 1'b1;
    step(32'h0000_0040, 8'h00, 1'b0, 32'h0, 1'b0);
    rst = 1'b0;
    check(irq_p == 1'b0 && irq_l == 1'b0, "R1 irq low after mid-run reset",
          {30'b0, irq_p, irq_l}, 32'h0);
    step(32'h0, 8'h04, 1'b0, 32'h0, 1'b1);
    check(rdata_l == 32'h0, "R1 match cleared by reset", rdata_l, 32'h0);
    step(32'h0, 8'h00, 1'b0, 32'h0, 1'b1);
    check(rdata_l == 32'hFFFF_FFFF, "R1 enable back to ones", rdata_l, 32'hFFFF_FFFF);
    // R10 hold without read
    step(32'h0, 8'h04, 1'b0, 32'h0, 1'b0);
    check(rdata_l == 32'hFFFF_FFFF, "R10 rdata held", rdata_l, 32'hFFFF_FFFF);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule